// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small content-addressable array. Software-facing logic elsewhere writes words into numbered slots. A search then finds every slot whose contents agree with a search argument. Only the bit positions that a separate mask register enables take part in that comparison. Every slot is compared in the same clock, and the outcome is held as one hit bit per slot.

A read phase turns the hit vector into a stream. After a start pulse, the block emits each hit slot's index and contents, one per clock, beginning with the lowest index. It then pulses a completion flag. The argument and the mask are loaded through their own strobes. Changing either one invalidates the held hit vector until the next search.

Top module: `cam_masked`

## Requirements
- R1: A write (`wr_en` high at a clock edge) stores `wr_data` into slot `wr_idx` and marks that slot occupied. The stored value is visible from the next clock.
- R2: Reset (synchronous, active high) marks every slot unoccupied and clears `match_vec`, `rd_valid`, `rd_done`, `rd_idx` and `rd_data` to zero.
- R3: A `search` pulse at a clock edge sets `match_vec[i]` to 1, from the next clock, for each occupied slot i whose stored word equals the held argument at every bit position where the held mask is 1. Every other bit of `match_vec` is set to 0.
- R4: Bit positions where the mask is 0 never cause a mismatch. An all-zero mask therefore hits every occupied slot.
- R5: An unoccupied slot never sets its `match_vec` bit, whatever the argument and mask hold.
- R6: A clock edge with `arg_load` or `key_load` high loads the new argument or mask and clears `match_vec` to zero. A `search` asserted at the same edge is then discarded.
- R7: Without `search`, `arg_load` or `key_load` at an edge, `match_vec` keeps its value. This holds even while slots are being written.
- R8: `read_start` at edge E0 snapshots `match_vec`. At edges E1, E2, … the block presents one hit slot per clock, lowest index first. Each such slot raises `rd_valid` for one cycle, with `rd_idx` set to the slot and `rd_data` to its contents.
- R9: `rd_done` pulses for exactly one cycle, at the edge after the last emitted slot. When the snapshot holds no hits, it pulses at E1. It is never high together with `rd_valid`.
- R10: A `read_start` that arrives while a readout is running is ignored, and the running sequence is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_data | input | WIDTH | Word to store |
| arg_load | input | 1 | Load search argument |
| arg_in | input | WIDTH | New argument |
| key_load | input | 1 | Load comparison mask |
| key_in | input | WIDTH | New mask (1 = compare this bit) |
| search | input | 1 | Run parallel comparison |
| read_start | input | 1 | Begin sequential readout of hits |
| match_vec | output | WORDS | Held hit vector, one bit per slot |
| rd_valid | output | 1 | Readout beat valid |
| rd_idx | output | IDX_W | Slot index of readout beat |
| rd_data | output | WIDTH | Stored word of readout beat |
| rd_done | output | 1 | Readout finished pulse |

## Verification
A wrong occupancy bit or a wrongly stored word appears on `match_vec` one clock after the next search. It shows as an extra or missing hit under a full or partial mask. A stale hit vector that survives an argument or mask load appears on `match_vec` one clock after the load. A wrong scan pointer shows at once on the readout. Slots come out out of order, are repeated or are skipped, or `rd_done` arrives early or late relative to the count of set hit bits.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int CAM_WORDS_DEF = 8;
    localparam int CAM_WIDTH_DEF = 16;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_t;

    typedef struct packed {
        logic load_arg;
        logic load_key;
        logic search;
    } cam_cmd_t;

    function automatic logic cmd_clears(input cam_cmd_t c);
        return c.load_arg | c.load_key;
    endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int WORDS = cam_pkg::CAM_WORDS_DEF,
    parameter int WIDTH = cam_pkg::CAM_WIDTH_DEF,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [WORDS-1:0][WIDTH-1:0]  words,
    output logic [WORDS-1:0]             valid_vec
);

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_vec[g] <= 1'b0;
                    words[g]     <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    valid_vec[g] <= 1'b1;
                    words[g]     <= wr_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cam_match.sv
module cam_match
    import cam_pkg::*;
#(
    parameter int WORDS = CAM_WORDS_DEF,
    parameter int WIDTH = CAM_WIDTH_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  cam_cmd_t                     cmd,
    input  logic [WIDTH-1:0]             arg_in,
    input  logic [WIDTH-1:0]             key_in,
    input  logic [WORDS-1:0][WIDTH-1:0]  words,
    input  logic [WORDS-1:0]             valid_vec,
    output logic [WORDS-1:0]             match_q
);

    logic [WIDTH-1:0] arg_q;
    logic [WIDTH-1:0] key_q;
    logic [WORDS-1:0] hit;

    generate
        for (genvar g = 0; g < WORDS; g++) begin : g_cmp
            assign hit[g] = valid_vec[g] && (((words[g] ^ arg_q) & key_q) == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q   <= '0;
            key_q   <= '0;
            match_q <= '0;
        end else begin
            if (cmd.load_arg) arg_q <= arg_in;
            if (cmd.load_key) key_q <= key_in;
            if (cmd_clears(cmd)) begin
                match_q <= '0;
            end else if (cmd.search) begin
                match_q <= hit;
            end
        end
    end

endmodule

// File: rtl/cam_scan.sv
module cam_scan
    import cam_pkg::*;
#(
    parameter int WORDS = CAM_WORDS_DEF,
    parameter int WIDTH = CAM_WIDTH_DEF,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [WORDS-1:0]             match_vec,
    input  logic [WORDS-1:0][WIDTH-1:0]  words,
    output logic                         rd_valid,
    output logic [IDX_W-1:0]             rd_idx,
    output logic [WIDTH-1:0]             rd_data,
    output logic                         rd_done
);

    scan_state_t      state_q;
    logic [WORDS-1:0] pending_q;
    logic [IDX_W-1:0] pick;
    logic             any;

    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (pending_q[i]) begin
                pick = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SCAN_IDLE;
            pending_q <= '0;
            rd_valid  <= 1'b0;
            rd_done   <= 1'b0;
            rd_idx    <= '0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
            case (state_q)
                SCAN_IDLE: begin
                    if (start) begin
                        pending_q <= match_vec;
                        state_q   <= SCAN_RUN;
                    end
                end
                SCAN_RUN: begin
                    if (any) begin
                        rd_valid        <= 1'b1;
                        rd_idx          <= pick;
                        rd_data         <= words[pick];
                        pending_q[pick] <= 1'b0;
                    end else begin
                        rd_done <= 1'b1;
                        state_q <= SCAN_IDLE;
                    end
                end
                default: state_q <= SCAN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cam_masked.sv
module cam_masked
    import cam_pkg::*;
#(
    parameter int WORDS = CAM_WORDS_DEF,
    parameter int WIDTH = CAM_WIDTH_DEF,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              arg_load,
    input  logic [WIDTH-1:0]  arg_in,
    input  logic              key_load,
    input  logic [WIDTH-1:0]  key_in,
    input  logic              search,
    input  logic              read_start,
    output logic [WORDS-1:0]  match_vec,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_done
);

    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [WORDS-1:0]            valid_vec;
    cam_cmd_t                    cmd;

    assign cmd = '{load_arg: arg_load, load_key: key_load, search: search};

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .words     (words),
        .valid_vec (valid_vec)
    );

    cam_match #(.WORDS(WORDS), .WIDTH(WIDTH)) u_match (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .arg_in    (arg_in),
        .key_in    (key_in),
        .words     (words),
        .valid_vec (valid_vec),
        .match_q   (match_vec)
    );

    cam_scan #(.WORDS(WORDS), .WIDTH(WIDTH)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .start     (read_start),
        .match_vec (match_vec),
        .words     (words),
        .rd_valid  (rd_valid),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .rd_done   (rd_done)
    );

endmodule

// File: rtl/cam_masked_chk.sv
module cam_masked_chk #(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             arg_load,
    input logic             key_load,
    input logic             search,
    input logic [WORDS-1:0] match_vec,
    input logic [WORDS-1:0] valid_vec,
    input logic             rd_valid,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_done
);

    p_hit_needs_occupied_r5: assert property (@(posedge clk) disable iff (rst)
        (match_vec & ~valid_vec) == '0);

    p_load_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (arg_load || key_load) |=> (match_vec == '0));

    p_hold_match_r7: assert property (@(posedge clk) disable iff (rst)
        (!search && !arg_load && !key_load) |=> $stable(match_vec));

    p_ascending_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (!rd_valid || (rd_idx > $past(rd_idx))));

    p_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

endmodule

bind cam_masked cam_masked_chk #(.WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arg_load  (arg_load),
    .key_load  (key_load),
    .search    (search),
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_done   (rd_done)
);

// File: tb/cam_masked_bench.sv
`timescale 1ns/1ps
module cam_masked_bench;

    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IDX_W = 3;
    localparam int NVEC  = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [WIDTH-1:0]  wr_data = '0;
    logic              arg_load = 1'b0;
    logic [WIDTH-1:0]  arg_in = '0;
    logic              key_load = 1'b0;
    logic [WIDTH-1:0]  key_in = '0;
    logic              search = 1'b0;
    logic              read_start = 1'b0;
    logic [WORDS-1:0]  match_vec;
    logic              rd_valid;
    logic [IDX_W-1:0]  rd_idx;
    logic [WIDTH-1:0]  rd_data;
    logic              rd_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [WIDTH-1:0] model [WORDS];

    // {argument, mask, expected hit vector}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h1234, 16'hFFFF, 8'b0000_0001},
        {16'h1200, 16'hFF00, 8'b0010_0011},
        {16'h0034, 16'h00FF, 8'b0100_0001},
        {16'h9999, 16'h0000, 8'b0111_1111},
        {16'hFFFF, 16'hFFFF, 8'b0001_0000},
        {16'h0000, 16'h8000, 8'b0110_1011},
        {16'h9999, 16'hFFFF, 8'b0000_0000}
    };

    cam_masked #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cam_masked (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .arg_load(arg_load), .arg_in(arg_in), .key_load(key_load), .key_in(key_in),
        .search(search), .read_start(read_start), .match_vec(match_vec),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .rd_done(rd_done)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input int idx, input logic [WIDTH-1:0] d);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = d;
    endtask

    task automatic load_both(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
        arg_load = 1'b1; arg_in = a; key_load = 1'b1; key_in = k;
        @(negedge clk);
        arg_load = 1'b0; key_load = 1'b0;
    endtask

    task automatic do_search;
        search = 1'b1;
        @(negedge clk);
        search = 1'b0;
    endtask

    // R8 R9 R10: readout of exp hit vector, optional stray restart
    task automatic readout(input logic [WORDS-1:0] exp, input bit restart);
        int got_idx [WORDS];
        int n = 0;
        int nexp = 0;
        int k = 0;
        bit done_seen = 0;
        read_start = 1'b1;
        @(negedge clk);
        read_start = restart;
        for (int c = 0; c < WORDS + 3 && !done_seen; c++) begin
            @(negedge clk);
            read_start = 1'b0;
            if (rd_valid && rd_done) check("R9 valid with done", 1, 0);
            if (rd_valid) begin
                if (n < WORDS) begin
                    got_idx[n] = int'(rd_idx);
                    check("R8 readout data", rd_data, model[rd_idx]);
                end
                n++;
            end
            if (rd_done) done_seen = 1;
        end
        for (int i = 0; i < WORDS; i++) if (exp[i]) nexp++;
        check(restart ? "R10 beat count" : "R9 beat count before done", n, nexp);
        check("R9 done seen", done_seen, 1);
        for (int i = 0; i < WORDS; i++) begin
            if (exp[i]) begin
                if (k < n && k < WORDS) check("R8 order", got_idx[k], i);
                k++;
            end
        end
        @(negedge clk);
        check("R9 done single pulse", rd_done, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL R8 watchdog: actual=hung expected=finished");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 match_vec", match_vec, 0);
        check("R2 rd_valid", rd_valid, 0);
        check("R2 rd_done", rd_done, 0);
        check("R2 rd_idx", rd_idx, 0);
        check("R2 rd_data", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: fill slots 0..6, slot 7 stays unoccupied
        do_write(0, 16'h1234);
        do_write(1, 16'h12FF);
        do_write(2, 16'hABCD);
        do_write(3, 16'h0000);
        do_write(4, 16'hFFFF);
        do_write(5, 16'h1200);
        do_write(6, 16'h5634);

        // R3 R4 R5: table walk
        for (int v = 0; v < NVEC; v++) begin
            load_both(VEC[v][39:24], VEC[v][23:8]);
            check("R6 cleared after load", match_vec, 0);
            do_search();
            check("R3 R4 R5 hit vector", match_vec, VEC[v][7:0]);
        end

        // R8 R9: readout of upper-byte match
        load_both(16'h1200, 16'hFF00);
        do_search();
        check("R3 upper byte", match_vec, 8'b0010_0011);
        readout(8'b0010_0011, 0);

        // R10: stray start mid-scan
        readout(8'b0010_0011, 1);

        // R7: writes do not move the hit vector
        do_write(7, 16'h12AA);
        check("R7 hold during write", match_vec, 8'b0010_0011);
        // R1: new slot now hits
        do_search();
        check("R1 written slot matches", match_vec, 8'b1010_0011);
        readout(8'b1010_0011, 0);

        // R6: load wins over simultaneous search
        arg_load = 1'b1; arg_in = 16'h1200; search = 1'b1;
        @(negedge clk);
        arg_load = 1'b0; search = 1'b0;
        check("R6 load beats search", match_vec, 0);

        // R9: empty readout finishes at once
        readout(8'b0000_0000, 0);

        // R2 R5: reset empties slots, zero mask matches nothing
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        load_both(16'h0000, 16'h0000);
        do_search();
        check("R5 unoccupied after reset", match_vec, 0);
        do_write(2, 16'h7777);
        do_search();
        check("R4 zero mask single slot", match_vec, 8'b0000_0100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule